// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block performs the entry half of exception handling for a small 32-bit soft processor. Each cycle it looks at four request lines: hardware break, memory-management fault, hardware exception and external interrupt. It picks at most one of them. In a single clock edge it then redirects instruction fetch to that class's fixed vector and issues one write of a return address to a fixed general register. It also produces the updated machine status word and records the fault context in its exception-status, fault-address and branch-target registers.

The surrounding pipeline supplies the current PC and three flags. One says the instruction sits in a branch delay slot, one says it carries an immediate prefix, and one says the branch before it was immediate-prefixed. It also supplies the pending branch target, the fault attributes and the present status word. The pipeline writes `msrOut` back into its status register whenever `msrWe` pulses. It clears its delay-slot and prefix flags when `pipeFlagClr` pulses. All outputs are registered, so they appear one clock after the requests are sampled.

Top module: `exc_entry_seq`

## Requirements
- R1: A hardware exception writes PC+4 to register 17, redirects fetch to 0x20 and sets status bit 9 (exception in progress) in `msrOut`.
- R2: On every accepted entry, `msrOut` copies the incoming bit 13 (translation on) into bit 14 and bit 11 (user mode) into bit 12, clears bits 13 and 11, and passes all other bits through except those an entry class sets.
- R3: On a hardware or MMU entry, bit 12 of `esrOut` is set and `btrOut` takes the branch target when `inDelaySlot` is high; otherwise bit 12 is cleared and `btrOut` is kept. A hardware exception leaves the other `esrOut` bits unchanged.
- R4: An MMU fault loads `earOut` with the fault address and writes `esrOut` code 16 + 2·miss + fetch in bits 4:0 (16 data protection, 17 fetch protection, 18 data miss, 19 fetch miss).
- R5: `esrOut` bit 10 is set when the MMU fault is a data-side store, and stays clear for fetch faults even if `mmuIsStore` is high.
- R6: An MMU fault writes a return address to register 17 and redirects fetch to 0x20. The address is PC-8 in a delay slot after an immediate-prefixed branch, PC-4 in any other delay slot, PC-4 for an immediate-prefixed instruction and PC otherwise.
- R7: An interrupt is accepted only when status bit 1 (enable) is set, bits 9 and 3 are clear and `inDelaySlot` is low. It then writes PC to register 14 and redirects fetch to 0x10.
- R8: A hardware break writes PC to register 16, redirects fetch to 0x18 and sets status bit 3 (break in progress).
- R9: `pipeFlagClr` pulses on hardware and MMU entries only.
- R10: A hardware exception request has no effect while `excCfgEn` is low.
- R11: An MMU request that arrives while status bit 9 is set, with the last accepted entry an MMU fault and bit 9 seen set in every cycle since, pulses `recursiveFault` and is not accepted.
- R12: Priority is break, MMU, hardware exception, interrupt. `takenOh` is one-hot with bit 3 break, 2 MMU, 1 hardware exception, 0 interrupt.
- R13: All updates of one entry take effect on one edge. `fetchRedirect`, `linkWe`, `msrWe`, `takenOh`, `pipeFlagClr` and `recursiveFault` are single-cycle pulses. `esrOut`, `earOut`, `btrOut` and `msrOut` hold between entries, and synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqBreak | input | 1 | Hardware break request |
| reqMmu | input | 1 | MMU fault request |
| reqHwExc | input | 1 | Hardware exception request |
| reqIrq | input | 1 | External interrupt request |
| excCfgEn | input | 1 | Core configured with hardware exceptions |
| mmuIsFetch | input | 1 | MMU fault came from instruction fetch |
| mmuIsStore | input | 1 | MMU data fault came from a store |
| mmuIsMiss | input | 1 | MMU fault is a TLB miss (else protection) |
| faultAddr | input | 32 | Faulting address |
| curPc | input | 32 | PC of the excepting instruction |
| inDelaySlot | input | 1 | Instruction is in a branch delay slot |
| instImmPfx | input | 1 | Instruction has an immediate prefix |
| branchImmPfx | input | 1 | Preceding branch had an immediate prefix |
| branchTarget | input | 32 | Pending branch target |
| msrIn | input | 32 | Current machine status word |
| takenOh | output | 4 | One-hot accepted class pulse |
| recursiveFault | output | 1 | Fatal nested MMU fault pulse |
| fetchRedirect | output | 1 | Fetch redirect pulse |
| fetchPc | output | 32 | Vector address |
| linkWe | output | 1 | Link register write pulse |
| linkIdx | output | 5 | Link register index |
| linkData | output | 32 | Return address |
| msrWe | output | 1 | Status write pulse |
| msrOut | output | 32 | New status word |
| esrOut | output | 32 | Exception-status register |
| earOut | output | 32 | Fault-address register |
| btrOut | output | 32 | Branch-target register |
| pipeFlagClr | output | 1 | Clear delay-slot and prefix flags |

## Verification
The MMU path is driven with each combination of fetch or data side, miss or protection, and store or load. This tells the four status codes apart and shows that the store bit is masked on fetch faults. The return address is tried with no flags, an immediate-prefixed instruction, a plain delay slot and a delay slot after an immediate-prefixed branch, which gives the four rewind distances. Interrupts are offered with each single gating condition failing in turn. Requests are also stacked in the same cycle to expose the priority order. A hardware exception taken after an MMU fault shows that it keeps the earlier fault code while rewriting only the delay-slot bit.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // status word bit positions; each saved copy sits one above its live bit
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;
  // exception-status bit positions
  localparam int ESR_STORE = 10;
  localparam int ESR_DSLOT = 12;
  localparam int ESR_CODE_W = 5;
  localparam logic [ESR_CODE_W-1:0] ESR_MMU_BASE = 5'd16;

  typedef struct packed {
    logic takeBrk;
    logic takeMmu;
    logic takeHw;
    logic takeIrq;
    logic fatal;
  } entryStrobes_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reqBreak,
  input  logic          reqMmu,
  input  logic          reqHwExc,
  input  logic          reqIrq,
  input  logic          excCfgEn,
  input  logic          msrIe,
  input  logic          msrEip,
  input  logic          msrBip,
  input  logic          inDelaySlot,
  output entryStrobes_t strb
);
  logic mmuActive;
  logic hwOk, irqOk, mmuRecur, anyOther;

  always_comb begin
    hwOk     = reqHwExc & excCfgEn;
    irqOk    = reqIrq & msrIe & ~msrEip & ~msrBip & ~inDelaySlot;
    mmuRecur = reqMmu & mmuActive & msrEip;
    strb.takeBrk = reqBreak;
    strb.fatal   = ~reqBreak & mmuRecur;
    strb.takeMmu = ~reqBreak & reqMmu & ~mmuRecur;
    strb.takeHw  = ~reqBreak & ~reqMmu & hwOk;
    strb.takeIrq = ~reqBreak & ~reqMmu & ~hwOk & irqOk;
    anyOther     = strb.takeBrk | strb.takeHw | strb.takeIrq;
  end

  // tracks whether the handler now running was entered through an MMU fault
  always_ff @(posedge clk) begin
    if (rst)                mmuActive <= 1'b0;
    else if (strb.takeMmu)  mmuActive <= 1'b1;
    else if (anyOther)      mmuActive <= 1'b0;
    else if (!msrEip)       mmuActive <= 1'b0;
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  parameter logic [XLEN-1:0] VEC_EXC = 32'h20,
  parameter logic [XLEN-1:0] VEC_IRQ = 32'h10,
  parameter logic [XLEN-1:0] VEC_BRK = 32'h18,
  parameter logic [RIDX_W-1:0] LINK_EXC = 5'd17,
  parameter logic [RIDX_W-1:0] LINK_IRQ = 5'd14,
  parameter logic [RIDX_W-1:0] LINK_BRK = 5'd16
)(
  input  logic              clk,
  input  logic              rst,
  input  entryStrobes_t     strb,
  input  logic              mmuIsFetch,
  input  logic              mmuIsStore,
  input  logic              mmuIsMiss,
  input  logic [XLEN-1:0]   faultAddr,
  input  logic [XLEN-1:0]   curPc,
  input  logic              inDelaySlot,
  input  logic              instImmPfx,
  input  logic              branchImmPfx,
  input  logic [XLEN-1:0]   branchTarget,
  input  logic [XLEN-1:0]   msrIn,
  output logic [3:0]        takenOh,
  output logic              recursiveFault,
  output logic              fetchRedirect,
  output logic [XLEN-1:0]   fetchPc,
  output logic              linkWe,
  output logic [RIDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]   linkData,
  output logic              msrWe,
  output logic [XLEN-1:0]   msrOut,
  output logic [XLEN-1:0]   esrOut,
  output logic [XLEN-1:0]   earOut,
  output logic [XLEN-1:0]   btrOut,
  output logic              pipeFlagClr
);
  localparam int INSN_BYTES = 4;
  localparam int NPAIR = 2;
  localparam int LIVE_POS [NPAIR] = '{MSR_VM, MSR_UM};
  localparam int SAVE_POS [NPAIR] = '{MSR_VMS, MSR_UMS};

  logic [XLEN-1:0] msrStacked, msrNext, pcNext4, mmuLink, rewind, esrMmu, esrHw;
  logic [XLEN-1:0] dsMask;
  logic [ESR_CODE_W-1:0] mmuCode;
  logic entering, excLike;

  // save each live mode bit into its copy and clear the live bit
  always_comb begin
    msrStacked = msrIn;
    for (int i = 0; i < NPAIR; i++) begin
      msrStacked[SAVE_POS[i]] = msrIn[LIVE_POS[i]];
      msrStacked[LIVE_POS[i]] = 1'b0;
    end
  end

  always_comb begin
    entering = strb.takeBrk | strb.takeMmu | strb.takeHw | strb.takeIrq;
    excLike  = strb.takeMmu | strb.takeHw;
    msrNext  = msrStacked;
    if (excLike)      msrNext[MSR_EIP] = 1'b1;
    if (strb.takeBrk) msrNext[MSR_BIP] = 1'b1;
    pcNext4 = curPc + XLEN'(INSN_BYTES);
    if (inDelaySlot)     rewind = XLEN'(branchImmPfx ? 2 * INSN_BYTES : INSN_BYTES);
    else if (instImmPfx) rewind = XLEN'(INSN_BYTES);
    else                 rewind = '0;
    mmuLink = curPc - rewind;
    mmuCode = ESR_MMU_BASE + {3'b000, mmuIsMiss, mmuIsFetch};
    dsMask  = '0;
    dsMask[ESR_DSLOT] = 1'b1;
    esrMmu  = '0;
    esrMmu[ESR_CODE_W-1:0] = mmuCode;
    esrMmu[ESR_STORE] = mmuIsStore & ~mmuIsFetch;
    esrMmu[ESR_DSLOT] = inDelaySlot;
    esrHw   = (esrOut & ~dsMask) | (inDelaySlot ? dsMask : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      takenOh <= '0; recursiveFault <= 1'b0; fetchRedirect <= 1'b0;
      fetchPc <= '0; linkWe <= 1'b0; linkIdx <= '0; linkData <= '0;
      msrWe <= 1'b0; msrOut <= '0; esrOut <= '0; earOut <= '0;
      btrOut <= '0; pipeFlagClr <= 1'b0;
    end else begin
      takenOh        <= {strb.takeBrk, strb.takeMmu, strb.takeHw, strb.takeIrq};
      recursiveFault <= strb.fatal;
      fetchRedirect  <= entering;
      linkWe         <= entering;
      msrWe          <= entering;
      pipeFlagClr    <= excLike;
      if (entering) msrOut <= msrNext;
      if (excLike && inDelaySlot) btrOut <= branchTarget;
      if (strb.takeBrk) begin
        fetchPc <= VEC_BRK; linkIdx <= LINK_BRK; linkData <= curPc;
      end else if (strb.takeMmu) begin
        fetchPc <= VEC_EXC; linkIdx <= LINK_EXC; linkData <= mmuLink;
        esrOut  <= esrMmu;  earOut  <= faultAddr;
      end else if (strb.takeHw) begin
        fetchPc <= VEC_EXC; linkIdx <= LINK_EXC; linkData <= pcNext4;
        esrOut  <= esrHw;
      end else if (strb.takeIrq) begin
        fetchPc <= VEC_IRQ; linkIdx <= LINK_IRQ; linkData <= curPc;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  parameter logic [XLEN-1:0] VEC_EXC = 32'h20,
  parameter logic [XLEN-1:0] VEC_IRQ = 32'h10,
  parameter logic [XLEN-1:0] VEC_BRK = 32'h18,
  parameter logic [RIDX_W-1:0] LINK_EXC = 5'd17,
  parameter logic [RIDX_W-1:0] LINK_IRQ = 5'd14,
  parameter logic [RIDX_W-1:0] LINK_BRK = 5'd16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqBreak,
  input  logic              reqMmu,
  input  logic              reqHwExc,
  input  logic              reqIrq,
  input  logic              excCfgEn,
  input  logic              mmuIsFetch,
  input  logic              mmuIsStore,
  input  logic              mmuIsMiss,
  input  logic [XLEN-1:0]   faultAddr,
  input  logic [XLEN-1:0]   curPc,
  input  logic              inDelaySlot,
  input  logic              instImmPfx,
  input  logic              branchImmPfx,
  input  logic [XLEN-1:0]   branchTarget,
  input  logic [XLEN-1:0]   msrIn,
  output logic [3:0]        takenOh,
  output logic              recursiveFault,
  output logic              fetchRedirect,
  output logic [XLEN-1:0]   fetchPc,
  output logic              linkWe,
  output logic [RIDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]   linkData,
  output logic              msrWe,
  output logic [XLEN-1:0]   msrOut,
  output logic [XLEN-1:0]   esrOut,
  output logic [XLEN-1:0]   earOut,
  output logic [XLEN-1:0]   btrOut,
  output logic              pipeFlagClr
);
  entryStrobes_t strb;

  exc_entry_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .reqBreak(reqBreak), .reqMmu(reqMmu), .reqHwExc(reqHwExc), .reqIrq(reqIrq),
    .excCfgEn(excCfgEn),
    .msrIe(msrIn[MSR_IE]), .msrEip(msrIn[MSR_EIP]), .msrBip(msrIn[MSR_BIP]),
    .inDelaySlot(inDelaySlot),
    .strb(strb)
  );

  exc_entry_dp #(
    .XLEN(XLEN), .RIDX_W(RIDX_W),
    .VEC_EXC(VEC_EXC), .VEC_IRQ(VEC_IRQ), .VEC_BRK(VEC_BRK),
    .LINK_EXC(LINK_EXC), .LINK_IRQ(LINK_IRQ), .LINK_BRK(LINK_BRK)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .mmuIsFetch(mmuIsFetch), .mmuIsStore(mmuIsStore), .mmuIsMiss(mmuIsMiss),
    .faultAddr(faultAddr), .curPc(curPc), .inDelaySlot(inDelaySlot),
    .instImmPfx(instImmPfx), .branchImmPfx(branchImmPfx),
    .branchTarget(branchTarget), .msrIn(msrIn),
    .takenOh(takenOh), .recursiveFault(recursiveFault),
    .fetchRedirect(fetchRedirect), .fetchPc(fetchPc),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData),
    .msrWe(msrWe), .msrOut(msrOut), .esrOut(esrOut), .earOut(earOut),
    .btrOut(btrOut), .pipeFlagClr(pipeFlagClr)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  parameter logic [XLEN-1:0] VEC_IRQ = 32'h10,
  parameter logic [RIDX_W-1:0] LINK_IRQ = 5'd14
)(
  input logic              clk,
  input logic              rst,
  input logic              reqBreak,
  input logic              reqMmu,
  input logic              reqHwExc,
  input logic              reqIrq,
  input logic              excCfgEn,
  input logic [XLEN-1:0]   curPc,
  input logic [XLEN-1:0]   msrIn,
  input logic [3:0]        takenOh,
  input logic              recursiveFault,
  input logic              fetchRedirect,
  input logic [XLEN-1:0]   fetchPc,
  input logic              linkWe,
  input logic [RIDX_W-1:0] linkIdx,
  input logic [XLEN-1:0]   linkData,
  input logic              msrWe,
  input logic [XLEN-1:0]   msrOut,
  input logic              pipeFlagClr
);
  // R12
  taken_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(takenOh));
  // R12
  brk_wins_chk: assert property (@(posedge clk) disable iff (rst) reqBreak |=> takenOh == 4'b1000);
  // R7
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    takenOh[0] |-> (fetchPc == VEC_IRQ && linkIdx == LINK_IRQ && linkData == $past(curPc)));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reqIrq && !msrIn[MSR_IE]) |=> !takenOh[0]);
  // R2
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    msrWe |-> (!msrOut[MSR_VM] && !msrOut[MSR_UM]));
  // R2
  mode_save_chk: assert property (@(posedge clk) disable iff (rst)
    msrWe |-> (msrOut[MSR_VMS] == $past(msrIn[MSR_VM]) && msrOut[MSR_UMS] == $past(msrIn[MSR_UM])));
  // R11
  fatal_chk: assert property (@(posedge clk) disable iff (rst)
    recursiveFault |-> (takenOh == 4'b0000 && !fetchRedirect));
  // R10
  cfg_off_chk: assert property (@(posedge clk) disable iff (rst)
    (reqHwExc && !excCfgEn && !reqBreak && !reqMmu && !reqIrq) |=> !fetchRedirect);
  // R13
  link_with_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> (fetchRedirect && takenOh != 4'b0000));
  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    pipeFlagClr |-> (takenOh[2] || takenOh[1]));
endmodule

bind exc_entry_seq exc_entry_chk #(
  .XLEN(XLEN), .RIDX_W(RIDX_W), .VEC_IRQ(VEC_IRQ), .LINK_IRQ(LINK_IRQ)
) u_chk (
  .clk(clk), .rst(rst), .reqBreak(reqBreak), .reqMmu(reqMmu),
  .reqHwExc(reqHwExc), .reqIrq(reqIrq), .excCfgEn(excCfgEn),
  .curPc(curPc), .msrIn(msrIn), .takenOh(takenOh),
  .recursiveFault(recursiveFault), .fetchRedirect(fetchRedirect),
  .fetchPc(fetchPc), .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData),
  .msrWe(msrWe), .msrOut(msrOut), .pipeFlagClr(pipeFlagClr)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic clk = 1'b0;
  logic rst;
  logic reqBreak, reqMmu, reqHwExc, reqIrq, excCfgEn;
  logic mmuIsFetch, mmuIsStore, mmuIsMiss;
  logic [31:0] faultAddr, curPc, branchTarget, msrIn;
  logic inDelaySlot, instImmPfx, branchImmPfx;
  logic [3:0] takenOh;
  logic recursiveFault, fetchRedirect, linkWe, msrWe, pipeFlagClr;
  logic [31:0] fetchPc, linkData, msrOut, esrOut, earOut, btrOut;
  logic [4:0] linkIdx;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst(rst), .reqBreak(reqBreak), .reqMmu(reqMmu),
    .reqHwExc(reqHwExc), .reqIrq(reqIrq), .excCfgEn(excCfgEn),
    .mmuIsFetch(mmuIsFetch), .mmuIsStore(mmuIsStore), .mmuIsMiss(mmuIsMiss),
    .faultAddr(faultAddr), .curPc(curPc), .inDelaySlot(inDelaySlot),
    .instImmPfx(instImmPfx), .branchImmPfx(branchImmPfx),
    .branchTarget(branchTarget), .msrIn(msrIn), .takenOh(takenOh),
    .recursiveFault(recursiveFault), .fetchRedirect(fetchRedirect),
    .fetchPc(fetchPc), .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData),
    .msrWe(msrWe), .msrOut(msrOut), .esrOut(esrOut), .earOut(earOut),
    .btrOut(btrOut), .pipeFlagClr(pipeFlagClr)
  );

  localparam logic [31:0] IE = 32'h2, BIP = 32'h8, EIP = 32'h200;
  localparam logic [31:0] UM = 32'h800, UMS = 32'h1000, VM = 32'h2000, VMS = 32'h4000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reqBreak = 0; reqMmu = 0; reqHwExc = 0; reqIrq = 0;
    mmuIsFetch = 0; mmuIsStore = 0; mmuIsMiss = 0;
    inDelaySlot = 0; instImmPfx = 0; branchImmPfx = 0;
    msrIn = '0;
  endtask

  // one request cycle: inputs already set, cross the edge, sample at negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    idle();
    step();
  endtask

  task automatic t_reset();
    chk("R13 reset taken", {28'd0, takenOh}, 0);
    chk("R13 reset redirect", {31'd0, fetchRedirect}, 0);
    chk("R13 reset msr", msrOut, 0);
    chk("R13 reset esr", esrOut, 0);
    chk("R13 reset ear", earOut, 0);
    chk("R13 reset btr", btrOut, 0);
    chk("R13 reset link", linkData, 0);
  endtask

  task automatic t_hw_plain();
    curPc = 32'h1000; msrIn = VM | IE; reqHwExc = 1;
    step();
    chk("R1 hw taken", {28'd0, takenOh}, 4'b0010);
    chk("R1 hw link idx", {27'd0, linkIdx}, 17);
    chk("R1 hw link data", linkData, 32'h1004);
    chk("R1 hw vector", fetchPc, 32'h20);
    chk("R2 hw msr", msrOut, VMS | IE | EIP);
    chk("R3 hw esr no dslot", esrOut, 0);
    chk("R9 hw flag clear", {31'd0, pipeFlagClr}, 1);
    settle();
    chk("R13 pulse drops", {29'd0, fetchRedirect, msrWe, linkWe}, 0);
    chk("R13 msr held", msrOut, VMS | IE | EIP);
  endtask

  task automatic t_hw_dslot();
    curPc = 32'h2000; msrIn = UM; inDelaySlot = 1; branchTarget = 32'h3000;
    reqHwExc = 1;
    step();
    chk("R3 hw esr dslot", esrOut, 32'h1000);
    chk("R3 hw btr", btrOut, 32'h3000);
    chk("R2 hw msr user", msrOut, UMS | EIP);
    chk("R1 hw link dslot", linkData, 32'h2004);
    settle();
  endtask

  task automatic t_mmu_codes();
    // data load protection
    curPc = 32'h4000; faultAddr = 32'hDEAD0000; reqMmu = 1;
    step();
    chk("R12 mmu taken", {28'd0, takenOh}, 4'b0100);
    chk("R4 mmu esr 16", esrOut, 16);
    chk("R4 mmu ear", earOut, 32'hDEAD0000);
    chk("R6 mmu link idx", {27'd0, linkIdx}, 17);
    chk("R6 mmu link pc", linkData, 32'h4000);
    chk("R6 mmu vector", fetchPc, 32'h20);
    chk("R3 mmu btr kept", btrOut, 32'h3000);
    chk("R9 mmu flag clear", {31'd0, pipeFlagClr}, 1);
    settle();
    // hw exception keeps prior code
    curPc = 32'h100; reqHwExc = 1;
    step();
    chk("R3 hw keeps esr code", esrOut, 16);
    settle();
    // data store miss
    curPc = 32'h5000; faultAddr = 32'h1234; reqMmu = 1; mmuIsStore = 1; mmuIsMiss = 1;
    step();
    chk("R5 store miss esr", esrOut, 32'h412);
    chk("R4 ear store", earOut, 32'h1234);
    settle();
    // fetch miss with store asserted
    faultAddr = 32'h5678; reqMmu = 1; mmuIsFetch = 1; mmuIsStore = 1; mmuIsMiss = 1;
    step();
    chk("R5 fetch store masked esr", esrOut, 19);
    settle();
    // fetch protection
    reqMmu = 1; mmuIsFetch = 1;
    step();
    chk("R4 fetch prot esr", esrOut, 17);
    settle();
  endtask

  task automatic t_mmu_rewind();
    curPc = 32'h6008; inDelaySlot = 1; branchImmPfx = 1; branchTarget = 32'h7000;
    mmuIsMiss = 1; reqMmu = 1;
    step();
    chk("R6 rewind bimm dslot", linkData, 32'h6000);
    chk("R3 mmu esr dslot", esrOut, 32'h1012);
    chk("R3 mmu btr", btrOut, 32'h7000);
    settle();
    curPc = 32'h6008; inDelaySlot = 1; reqMmu = 1; branchTarget = 32'h7100;
    step();
    chk("R6 rewind dslot", linkData, 32'h6004);
    settle();
    curPc = 32'h8004; instImmPfx = 1; reqMmu = 1;
    step();
    chk("R6 rewind imm", linkData, 32'h8000);
    chk("R3 mmu esr nodslot", esrOut, 16);
    settle();
  endtask

  task automatic t_recursive();
    curPc = 32'hA000; faultAddr = 32'h11; reqMmu = 1;
    step();
    chk("R11 first mmu taken", {28'd0, takenOh}, 4'b0100);
    msrIn = EIP; reqMmu = 1; faultAddr = 32'h22;
    step();
    chk("R11 recursive flagged", {31'd0, recursiveFault}, 1);
    chk("R11 recursive not taken", {28'd0, takenOh}, 0);
    chk("R11 ear unchanged", earOut, 32'h11);
    settle();
    settle();
  endtask

  task automatic t_cfg_off();
    excCfgEn = 0; curPc = 32'hB000; reqHwExc = 1; inDelaySlot = 1;
    step();
    chk("R10 cfg off no redirect", {31'd0, fetchRedirect}, 0);
    chk("R10 cfg off esr kept", esrOut, 16);
    settle();
    excCfgEn = 1;
  endtask

  task automatic t_irq();
    curPc = 32'h9000; msrIn = IE | UM | VM; reqIrq = 1;
    step();
    chk("R7 irq taken", {28'd0, takenOh}, 4'b0001);
    chk("R7 irq link idx", {27'd0, linkIdx}, 14);
    chk("R7 irq link", linkData, 32'h9000);
    chk("R7 irq vector", fetchPc, 32'h10);
    chk("R2 irq msr", msrOut, VMS | UMS | IE);
    chk("R9 irq no flag clear", {31'd0, pipeFlagClr}, 0);
    chk("R13 ear held", earOut, 32'h11);
    settle();
    msrIn = 0; reqIrq = 1; step();
    chk("R7 irq disabled", {31'd0, fetchRedirect}, 0); settle();
    msrIn = IE | EIP; reqIrq = 1; step();
    chk("R7 irq blocked by exc", {31'd0, fetchRedirect}, 0); settle();
    msrIn = IE | BIP; reqIrq = 1; step();
    chk("R7 irq blocked by break", {31'd0, fetchRedirect}, 0); settle();
    msrIn = IE; inDelaySlot = 1; reqIrq = 1; step();
    chk("R7 irq blocked by dslot", {31'd0, fetchRedirect}, 0); settle();
  endtask

  task automatic t_break();
    curPc = 32'hC000; msrIn = VM | EIP; reqBreak = 1;
    step();
    chk("R8 brk taken", {28'd0, takenOh}, 4'b1000);
    chk("R8 brk link idx", {27'd0, linkIdx}, 16);
    chk("R8 brk link", linkData, 32'hC000);
    chk("R8 brk vector", fetchPc, 32'h18);
    chk("R8 brk msr", msrOut, VMS | EIP | BIP);
    settle();
  endtask

  task automatic t_priority();
    msrIn = IE; curPc = 32'hD000;
    reqBreak = 1; reqMmu = 1; reqHwExc = 1; reqIrq = 1;
    step();
    chk("R12 all four -> break", {28'd0, takenOh}, 4'b1000);
    settle();
    msrIn = IE; reqMmu = 1; reqHwExc = 1; reqIrq = 1;
    step();
    chk("R12 mmu over hw", {28'd0, takenOh}, 4'b0100);
    settle();
    msrIn = IE; reqHwExc = 1; reqIrq = 1;
    step();
    chk("R12 hw over irq", {28'd0, takenOh}, 4'b0010);
    settle();
    msrIn = IE; excCfgEn = 0; reqHwExc = 1; reqIrq = 1;
    step();
    chk("R10 hw off lets irq", {28'd0, takenOh}, 4'b0001);
    settle();
    excCfgEn = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    excCfgEn = 1; faultAddr = '0; curPc = '0; branchTarget = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_hw_plain();
    t_hw_dslot();
    t_mmu_codes();
    t_mmu_rewind();
    t_recursive();
    t_cfg_off();
    t_irq();
    t_break();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule